// File: doc/BRIEF.md
# Root-Port Interrupt Aggregator

This block gathers the interrupt sources of a PCIe root-port bridge into one 32-bit status word and one combined interrupt line. Single-cycle event pulses from the link layer (completion timeout, power-management messages, error messages) are latched into sticky status bits. The levels of the four legacy INTx lines are copied into status bits. Software clears the sticky bits by writing ones to them.

A mask word decides which status bits may raise the interrupt line. Software never writes the mask directly. It changes the mask through two strobe registers: writing ones to the enable register clears mask bits, and writing ones to the disable register sets them. No read-modify-write sequence is needed, so two handlers that touch different sources cannot race. The registers sit on a simple 32-bit bus. Writes take effect on the clock edge, and reads return data combinationally from the address.

Top module: `rp_irq_aggregator`

## Requirements
- R1: After reset every status bit is 0, the mask reads 0x1FFF8000 (all implemented sources masked), and irqOut is 0.
- R2: A one-cycle pulse on an event input sets its status bit at the clock edge, and the bit stays set after the pulse ends. The bit positions are: completion timeout bit 15, PME message bit 24, PME turn-off acknowledge bit 25, correctable error bit 26, non-fatal error bit 27, fatal error bit 28.
- R3: A write to the status register (offset 0x4C0) clears every event status bit written with 1 and leaves bits written with 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 16+2·x follows the level of intxLevel[x] one cycle later (A=bit 16, B=18, C=20, D=22). A clearing write has no effect on such a bit while its line stays high. Bits 17, 19, 21 and 23 read 0.
- R6: Writing 1 to a bit of the enable register (offset 0x4C8) clears that mask bit. Writing 0 leaves it unchanged.
- R7: Writing 1 to a bit of the disable register (offset 0x4CC) sets that mask bit. Writing 0 leaves it unchanged. The mask changes only through these two registers.
- R8: The mask reads at offset 0x4C4. Only bits 15 and 16..28 are implemented: writes to other positions are ignored, and those positions read 0.
- R9: irqOut is registered. It is high in the cycle after any status bit is 1 while its mask bit is 0, and low otherwise.
- R10: Reads of the enable register, the disable register or any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| cplTimeoutEvt | input | 1 | Completion-timeout event pulse |
| pmeMsgEvt | input | 1 | PME message received pulse |
| pmeAckEvt | input | 1 | PME turn-off acknowledge received pulse |
| corrErrEvt | input | 1 | Correctable-error message pulse |
| nonFatalErrEvt | input | 1 | Non-fatal error message pulse |
| fatalErrEvt | input | 1 | Fatal error message pulse |
| intxLevel | input | 4 | Legacy INTx levels, bit 0 = A .. bit 3 = D |
| irqOut | output | 1 | Combined interrupt |

## Verification
The sequence first drives single events and grouped events while every source is masked. This separates latching into status from raising irqOut. It then enables sources one at a time, so an output that ignores the mask, or uses it inverted, shows up. Clearing writes that carry all zeros, a single bit, or all ones separate true write-one-to-clear from plain overwrite. The INTx lines are toggled and cleared while still high, which separates level-following bits from sticky ones. Directed cases cover a pulse and a clear in the same cycle, the one-cycle delay of irqOut, writes to unimplemented mask bits, and reads of the write-only and unmapped offsets.

// File: rtl/rp_irq_pkg.sv
package rp_irq_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int NUM_EVT   = 6;
  localparam int NUM_INTX  = 4;
  localparam int INTX_BASE = 16;
  localparam int INTX_SPAN = 2 * NUM_INTX;

  localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h4C0;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 12'h4C4;
  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 12'h4C8;
  localparam logic [ADDR_W-1:0] OFS_DISABLE = 12'h4CC;

  // bit 15 plus bits 16..28
  localparam logic [DATA_W-1:0] IMPL_BITS = 32'h1FFF_8000;

  // status position of each event input, index order matches evtPulse
  function automatic int evtPos(input int idx);
    case (idx)
      0:       evtPos = 15;  // completion timeout
      1:       evtPos = 24;  // PME message
      2:       evtPos = 25;  // PME turn-off ack
      3:       evtPos = 26;  // correctable
      4:       evtPos = 27;  // non-fatal
      default: evtPos = 28;  // fatal
    endcase
  endfunction

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK
  } rdSelT;

  typedef struct packed {
    logic              clrStatus;
    logic              enMask;
    logic              disMask;
    logic [DATA_W-1:0] data;
    rdSelT             rdSel;
  } ctrlStrobeT;
endpackage

// File: rtl/rp_irq_ctrl.sv
module rp_irq_ctrl
  import rp_irq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobeT        strobes
);
  always_comb begin
    strobes.clrStatus = regWrEn && (regAddr == OFS_STATUS);
    strobes.enMask    = regWrEn && (regAddr == OFS_ENABLE);
    strobes.disMask   = regWrEn && (regAddr == OFS_DISABLE);
    strobes.data      = regWrData & IMPL_BITS;
    case (regAddr)
      OFS_STATUS: strobes.rdSel = RD_STATUS;
      OFS_MASK:   strobes.rdSel = RD_MASK;
      default:    strobes.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/rp_irq_datapath.sv
module rp_irq_datapath
  import rp_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobes,
  input  logic [NUM_EVT-1:0]  evtPulse,
  input  logic [NUM_INTX-1:0] intxLevel,
  output logic [DATA_W-1:0]   statusQ,
  output logic [DATA_W-1:0]   maskQ,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqQ
);
  logic [DATA_W-1:0] statusD;
  logic [DATA_W-1:0] maskD;
  logic [DATA_W-1:0] clrBits;

  assign clrBits = strobes.clrStatus ? strobes.data : '0;

  always_comb begin
    statusD = '0;
    for (int e = 0; e < NUM_EVT; e++) begin
      // a new pulse wins over a clear in the same cycle
      statusD[evtPos(e)] = evtPulse[e] | (statusQ[evtPos(e)] & ~clrBits[evtPos(e)]);
    end
    for (int x = 0; x < NUM_INTX; x++) begin
      statusD[INTX_BASE + 2*x] = intxLevel[x];
    end
  end

  always_comb begin
    maskD = maskQ;
    if (strobes.enMask)  maskD = maskD & ~strobes.data;
    if (strobes.disMask) maskD = maskD | strobes.data;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= IMPL_BITS;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      irqQ    <= |(statusQ & ~maskQ);
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_STATUS: rdData = statusQ;
      RD_MASK:   rdData = maskQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/rp_irq_aggregator.sv
module rp_irq_aggregator
  import rp_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              cplTimeoutEvt,
  input  logic              pmeMsgEvt,
  input  logic              pmeAckEvt,
  input  logic              corrErrEvt,
  input  logic              nonFatalErrEvt,
  input  logic              fatalErrEvt,
  input  logic [3:0]        intxLevel,
  output logic              irqOut
);
  ctrlStrobeT         strobes;
  logic [DATA_W-1:0]  statusVal;
  logic [DATA_W-1:0]  maskVal;
  logic [NUM_EVT-1:0] evtPulse;

  assign evtPulse = {fatalErrEvt, nonFatalErrEvt, corrErrEvt,
                     pmeAckEvt, pmeMsgEvt, cplTimeoutEvt};

  rp_irq_ctrl i_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobes   (strobes)
  );

  rp_irq_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .evtPulse  (evtPulse),
    .intxLevel (intxLevel),
    .statusQ   (statusVal),
    .maskQ     (maskVal),
    .rdData    (regRdData),
    .irqQ      (irqOut)
  );
endmodule

// File: rtl/rp_irq_checker.sv
module rp_irq_checker
  import rp_irq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [11:0] regAddr,
  input logic [31:0] regWrData,
  input logic        cplTimeoutEvt,
  input logic        fatalErrEvt,
  input logic [3:0]  intxLevel,
  input logic [31:0] statusVal,
  input logic [31:0] maskVal,
  input logic        irqOut
);
  logic maskWrite;
  assign maskWrite = regWrEn && (regAddr == OFS_ENABLE || regAddr == OFS_DISABLE);

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|(statusVal & ~maskVal)));

  assert_event_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    fatalErrEvt |=> statusVal[28]);

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cplTimeoutEvt && regWrEn && regAddr == OFS_STATUS && regWrData[15]) |=> statusVal[15]);

  assert_intx_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ({statusVal[22], statusVal[20], statusVal[18], statusVal[16]} == $past(intxLevel)));

  assert_enable_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_ENABLE) |=> ((maskVal & $past(regWrData) & IMPL_BITS) == '0));

  assert_mask_only_strobes_R7: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrite |=> $stable(maskVal));
endmodule

bind rp_irq_aggregator rp_irq_checker i_checker (
  .clk           (clk),
  .rstN          (rstN),
  .regWrEn       (regWrEn),
  .regAddr       (regAddr),
  .regWrData     (regWrData),
  .cplTimeoutEvt (cplTimeoutEvt),
  .fatalErrEvt   (fatalErrEvt),
  .intxLevel     (intxLevel),
  .statusVal     (statusVal),
  .maskVal       (maskVal),
  .irqOut        (irqOut)
);

// File: tb/test_rp_irq_aggregator.sv
`timescale 1ns/1ps
module test_rp_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = 12'h000;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  evt = '0;
  logic [3:0]  intxLevel = '0;
  logic        irqOut;
  int nChecks = 0;
  int nErrors = 0;

  localparam logic [11:0] A_STAT = 12'h4C0;
  localparam logic [11:0] A_MASK = 12'h4C4;
  localparam logic [11:0] A_EN   = 12'h4C8;
  localparam logic [11:0] A_DIS  = 12'h4CC;

  always #10 clk = ~clk;

  rp_irq_aggregator i_rp_irq_aggregator (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .cplTimeoutEvt(evt[0]), .pmeMsgEvt(evt[1]), .pmeAckEvt(evt[2]),
    .corrErrEvt(evt[3]), .nonFatalErrEvt(evt[4]), .fatalErrEvt(evt[5]),
    .intxLevel(intxLevel), .irqOut(irqOut)
  );

  // op: 0 idle, 1 clear status, 2 enable, 3 disable
  typedef struct packed {
    logic [5:0]  evt;
    logic [3:0]  intx;
    logic [1:0]  op;
    logic [31:0] data;
    logic [31:0] expStatus;
    logic [31:0] expMask;
    logic        expIrq;
  } stepT;

  localparam int NSTEP = 17;
  localparam stepT STEPS [NSTEP] = '{
    '{6'h20, 4'h0, 2'd0, 32'h0000_0000, 32'h1000_0000, 32'h1FFF_8000, 1'b0},
    '{6'h00, 4'h0, 2'd2, 32'h1000_0000, 32'h1000_0000, 32'h0FFF_8000, 1'b1},
    '{6'h00, 4'h0, 2'd1, 32'h0000_0000, 32'h1000_0000, 32'h0FFF_8000, 1'b1},
    '{6'h00, 4'h0, 2'd1, 32'h1000_0000, 32'h0000_0000, 32'h0FFF_8000, 1'b0},
    '{6'h00, 4'h1, 2'd0, 32'h0000_0000, 32'h0001_0000, 32'h0FFF_8000, 1'b0},
    '{6'h00, 4'h1, 2'd2, 32'h0001_0000, 32'h0001_0000, 32'h0FFE_8000, 1'b1},
    '{6'h00, 4'h1, 2'd1, 32'h0001_0000, 32'h0001_0000, 32'h0FFE_8000, 1'b1},
    '{6'h00, 4'h0, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0FFE_8000, 1'b0},
    '{6'h00, 4'hA, 2'd0, 32'h0000_0000, 32'h0044_0000, 32'h0FFE_8000, 1'b0},
    '{6'h09, 4'h0, 2'd0, 32'h0000_0000, 32'h0400_8000, 32'h0FFE_8000, 1'b0},
    '{6'h00, 4'h0, 2'd2, 32'hFFFF_FFFF, 32'h0400_8000, 32'h0000_0000, 1'b1},
    '{6'h00, 4'h0, 2'd3, 32'h0400_0000, 32'h0400_8000, 32'h0400_0000, 1'b1},
    '{6'h00, 4'h0, 2'd1, 32'h0000_8000, 32'h0400_0000, 32'h0400_0000, 1'b0},
    '{6'h00, 4'h0, 2'd3, 32'hE000_7FFF, 32'h0400_0000, 32'h0400_0000, 1'b0},
    '{6'h00, 4'h0, 2'd3, 32'hFFFF_FFFF, 32'h0400_0000, 32'h1FFF_8000, 1'b0},
    '{6'h16, 4'h0, 2'd0, 32'h0000_0000, 32'h0F00_0000, 32'h1FFF_8000, 1'b0},
    '{6'h00, 4'h0, 2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1FFF_8000, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic readCheck(input string tag, input logic [11:0] addr, input logic [31:0] exp);
    regAddr = addr;
    #1;
    check(tag, regRdData, exp);
  endtask

  // drive at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [5:0] e, input logic [3:0] ix, input logic [1:0] op,
                      input logic [31:0] d);
    evt       = e;
    intxLevel = ix;
    regWrEn   = (op != 2'd0);
    regWrData = d;
    case (op)
      2'd1:    regAddr = A_STAT;
      2'd2:    regAddr = A_EN;
      2'd3:    regAddr = A_DIS;
      default: regAddr = 12'h000;
    endcase
    @(posedge clk);
    @(negedge clk);
    evt     = '0;
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    readCheck("R1 status after reset", A_STAT, 32'h0);
    readCheck("R1 mask after reset", A_MASK, 32'h1FFF_8000);
    check("R1 irq during reset", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);

    // vector walk: R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < NSTEP; i++) begin
      step(STEPS[i].evt, STEPS[i].intx, STEPS[i].op, STEPS[i].data);
      step(6'h0, STEPS[i].intx, 2'd0, 32'h0);
      readCheck($sformatf("R2 R3 R5 status step %0d", i), A_STAT, STEPS[i].expStatus);
      readCheck($sformatf("R6 R7 R8 mask step %0d", i), A_MASK, STEPS[i].expMask);
      check($sformatf("R9 irq step %0d", i), {31'b0, irqOut}, {31'b0, STEPS[i].expIrq});
    end

    // R4: a pulse and a clear of the same bit in one cycle
    step(6'h20, 4'h0, 2'd1, 32'h1000_0000);
    readCheck("R4 set beats clear", A_STAT, 32'h1000_0000);
    step(6'h0, 4'h0, 2'd1, 32'h1000_0000);
    readCheck("R3 clear after R4 case", A_STAT, 32'h0);

    // R9: the output lags the status by one cycle
    step(6'h0, 4'h0, 2'd2, 32'h0100_0000);
    step(6'h02, 4'h0, 2'd0, 32'h0);
    readCheck("R2 PME bit 24 set", A_STAT, 32'h0100_0000);
    check("R9 irq still low one cycle after set", {31'b0, irqOut}, 32'h0);
    step(6'h0, 4'h0, 2'd0, 32'h0);
    check("R9 irq high next cycle", {31'b0, irqOut}, 32'h1);
    step(6'h0, 4'h0, 2'd3, 32'h0100_0000);
    step(6'h0, 4'h0, 2'd0, 32'h0);
    check("R9 irq low after masking", {31'b0, irqOut}, 32'h0);
    readCheck("R3 masked bit stays pending", A_STAT, 32'h0100_0000);

    // R8: unimplemented bits of the mask cannot be cleared
    step(6'h0, 4'h0, 2'd2, 32'hE000_7FFF);
    readCheck("R8 enable of unimplemented bits ignored", A_MASK, 32'h1FFF_8000);

    // R10: write-only and unmapped offsets read 0
    readCheck("R10 enable reads zero", A_EN, 32'h0);
    readCheck("R10 disable reads zero", A_DIS, 32'h0);
    readCheck("R10 unmapped reads zero", 12'h4D0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule